// File: doc/BRIEF.md
# Display Pixel Register Readout Port

This block sits behind a composited display pixel FIFO. In normal operation the pixels stream straight through to the display path. When the register-route control bit is set, the stream output is idle. A host or DMA engine then pulls pixels one read at a time through a single readout register. The port counts pixels and lines against a programmable frame size. It stalls at the end of every line until software issues a line-start command, and it waits for a frame-start command before it delivers the first line of a frame.

Each read returns one of two words. In the default format the word carries one 24-bit RGB pixel together with valid, FIFO-empty and end-of-line flags. In packed mode the word carries two pixels reduced to 16 bits per pixel and no flags. A one-shot option limits the port to a single frame. The enable bit, or the register-route bit, flushes all pending state when it is cleared. A small prefetch buffer between the upstream FIFO and the readout register lets a packed read take two pixels in one access.

Top module: `dfr_readout_port`

## Requirements
- R1: After reset, and with the enable low, the readout word reads 0, `up_ready` is 0 and `st_valid` is 0.
- R2: With the enable high and the route bit low, `st_valid` equals `up_valid`, `st_data` equals `up_data` and `up_ready` equals `st_ready`. The readout word reads 0 and commands written in this mode have no effect.
- R3: In the unpacked format the readout word holds the pixel in bits 23:0, the valid flag in bit 24, the empty flag in bit 25 and the end-of-line flag in bit 26. Bits 31:27 are always 0.
- R4: A write with command bit 1 (frame start) while the port waits for a frame opens line 0. Each valid read then returns the next upstream pixel in order.
- R5: A read while the valid flag is low returns pixel field 0 and removes no pixel, so the next valid read returns the pixel that was pending.
- R6: After exactly `cfg_width` pixels of a line have been read, bit 26 is 1 and bit 24 is 0. A write with command bit 0 (line start) then clears bit 26 and opens the next line.
- R7: A line start written while a line is open is ignored. After `cfg_height` lines the port waits for a new frame start, and line starts are ignored while it waits.
- R8: With one-shot set, once a frame completes, later frame starts are ignored until the enable is cleared.
- R9: In packed mode a valid read returns the first pixel in bits 15:0 and the second in bits 31:16. Each pixel is reduced to 5/6/5 bits by keeping its most significant bits, red in the upper bits.
- R10: In packed mode with an odd line width, the last read of the line returns its single pixel in bits 15:0 with bits 31:16 at 0.
- R11: Clearing the enable flushes the port. The readout word and `up_ready` go to 0, buffered pixels are dropped, and after re-enabling no pixel is delivered until a frame start.
- R12: The empty flag (bit 25) is 1 exactly when no pixel is buffered in the port and `up_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Enables all output; clearing it flushes the port |
| cfg_reg_route | input | 1 | 1: pixels go to the readout register; 0: streaming output |
| cfg_pack | input | 1 | Packed two-pixel 16 bpp read format |
| cfg_oneshot | input | 1 | Deliver a single frame only |
| cfg_width | input | DIM_W | Pixels per line (1 or more) |
| cfg_height | input | DIM_W | Lines per frame (1 or more) |
| up_valid | input | 1 | Upstream FIFO has a pixel |
| up_data | input | 24 | Upstream RGB pixel |
| up_ready | output | 1 | Pixel taken from upstream this cycle |
| st_valid | output | 1 | Streaming output valid |
| st_data | output | 24 | Streaming output pixel |
| st_ready | input | 1 | Streaming output sink ready |
| host_rd | input | 1 | Read strobe for the readout register |
| host_rdata | output | 32 | Readout word for the current cycle |
| host_wr | input | 1 | Write strobe for the command bits |
| host_wcmd | input | 2 | Register write bits 31:30: [1] frame start, [0] line start |

## Verification
The bench goes after the line boundary. A port that miscounted would raise end-of-line one pixel early or late, or would keep delivering pixels into the next line without a line start. It reads while no pixel is ready and then checks the following pixel, so a design that popped on an invalid read would skip a pixel. Commands are written at the wrong moments: a line start mid-line, a line start after the last line, a frame start after a one-shot frame and a frame start in streaming mode. A port that honoured any of them would deliver pixels the bench does not expect. Packed mode is run with even and odd widths, which catches a swapped pixel order, wrong 5/6/5 bit selection, or a final read that pulls a pixel from the following line.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  localparam int unsigned PIX_W = 24;

  typedef enum logic [1:0] {
    ST_WAIT_FRAME = 2'd0,
    ST_LINE       = 2'd1,
    ST_WAIT_LINE  = 2'd2,
    ST_DONE       = 2'd3
  } port_state_e;

  // Reduce a 24-bit RGB pixel to 5/6/5 by keeping the top bits of each channel.
  function automatic logic [15:0] rgb_to_565(input logic [PIX_W-1:0] p);
    return {p[23:19], p[15:10], p[7:3]};
  endfunction

  // Unpacked readout word: flags above the 24-bit pixel field.
  function automatic logic [31:0] status_word(input logic eol, input logic empty,
                                              input logic valid, input logic [PIX_W-1:0] pix);
    return {5'd0, eol, empty, valid, (valid ? pix : {PIX_W{1'b0}})};
  endfunction

  // Packed readout word: n pixels (0..2), first pixel in the low half.
  function automatic logic [31:0] packed_word(input logic [1:0] n, input logic [PIX_W-1:0] p0,
                                              input logic [PIX_W-1:0] p1);
    logic [31:0] w;
    w = 32'd0;
    if (n != 2'd0) w[15:0]  = rgb_to_565(p0);
    if (n == 2'd2) w[31:16] = rgb_to_565(p1);
    return w;
  endfunction

endpackage

// File: rtl/dfr_prefetch.sv
module dfr_prefetch #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PIX_W = 24,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [PIX_W-1:0] push_data,
  input  logic [1:0]       pop_n,
  output logic [CNT_W-1:0] count,
  output logic [PIX_W-1:0] head0,
  output logic [PIX_W-1:0] head1
);

  logic [PIX_W-1:0] slot_q [DEPTH];
  logic [PIX_W-1:0] slot_d [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] after_pop;

  assign after_pop = cnt_q - CNT_W'(pop_n);

  // Oldest entry stays in slot 0: shift down by the pop count, then append.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_d[i] = slot_q[i];
      if (pop_n == 2'd1 && (i + 1) < DEPTH) slot_d[i] = slot_q[(i + 1) % DEPTH];
      if (pop_n == 2'd2 && (i + 2) < DEPTH) slot_d[i] = slot_q[(i + 2) % DEPTH];
      if (push && after_pop == CNT_W'(i)) slot_d[i] = push_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (flush) cnt_q <= '0;
    else            cnt_q <= after_pop + CNT_W'(push);
  end

  assign count = cnt_q;
  assign head0 = slot_q[0];
  assign head1 = slot_q[1 % DEPTH];

  // R5: a read never removes more pixels than are held.
  p_pop_le_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(pop_n) <= cnt_q));

  // R4: the buffer never holds more than its depth.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_W'(DEPTH)));

endmodule

// File: rtl/dfr_seq.sv
module dfr_seq
  import dfr_pkg::*;
#(
  parameter int unsigned DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             oneshot,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             cmd_frame,
  input  logic             cmd_line,
  input  logic [1:0]       pop_n,
  input  logic             fetch,
  output port_state_e      state,
  output logic             eol,
  output logic             fetch_allow,
  output logic [DIM_W-1:0] remain
);

  port_state_e      state_q;
  logic [DIM_W-1:0] col_q, fet_q, row_q;
  logic             eol_q;
  logic [DIM_W-1:0] col_next;
  logic             frame_go, line_go, line_done, last_row;

  assign frame_go  = cmd_frame && state_q == ST_WAIT_FRAME;
  assign line_go   = cmd_line  && state_q == ST_WAIT_LINE;
  assign col_next  = col_q + DIM_W'(pop_n);
  assign line_done = state_q == ST_LINE && pop_n != 2'd0 && col_next == width;
  assign last_row  = row_q == height - DIM_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_FRAME;
      col_q <= '0; fet_q <= '0; row_q <= '0; eol_q <= 1'b0;
    end else if (!active) begin
      state_q <= ST_WAIT_FRAME;
      col_q <= '0; fet_q <= '0; row_q <= '0; eol_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT_FRAME: if (frame_go) begin
          state_q <= ST_LINE;
          col_q <= '0; fet_q <= '0; row_q <= '0; eol_q <= 1'b0;
        end
        ST_LINE: begin
          col_q <= col_next;
          fet_q <= fet_q + DIM_W'(fetch);
          if (line_done) begin
            eol_q <= 1'b1;
            if (!last_row)    state_q <= ST_WAIT_LINE;
            else if (oneshot) state_q <= ST_DONE;
            else              state_q <= ST_WAIT_FRAME;
          end
        end
        ST_WAIT_LINE: if (line_go) begin
          state_q <= ST_LINE;
          col_q <= '0; fet_q <= '0; row_q <= row_q + DIM_W'(1); eol_q <= 1'b0;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign state       = state_q;
  assign eol         = eol_q;
  assign fetch_allow = state_q == ST_LINE && fet_q < width;
  assign remain      = width - col_q;

  // R6: no pixel leaves the port while the end-of-line flag is up.
  p_eol_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eol_q |-> pop_n == 2'd0);

  // R6: an open line never has reached its width.
  p_col_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINE) |-> col_q < width);

  // R7: pixels are fetched only inside an open line and never past its width.
  p_fetch_in_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (state_q == ST_LINE && fet_q < width));

  // R8: a finished one-shot frame stays finished while the port is active.
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && active) |=> state_q == ST_DONE);

  // R11: dropping out of the active mode returns to waiting for a frame.
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state_q == ST_WAIT_FRAME && !eol_q));

endmodule

// File: rtl/dfr_readout_port.sv
module dfr_readout_port
  import dfr_pkg::*;
#(
  parameter int unsigned DIM_W = 12,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_reg_route,
  input  logic             cfg_pack,
  input  logic             cfg_oneshot,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic             up_valid,
  input  logic [23:0]      up_data,
  output logic             up_ready,
  output logic             st_valid,
  output logic [23:0]      st_data,
  input  logic             st_ready,
  input  logic             host_rd,
  output logic [31:0]      host_rdata,
  input  logic             host_wr,
  input  logic [1:0]       host_wcmd
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             active, stream_on;
  logic             cmd_frame, cmd_line;
  port_state_e      state;
  logic             eol, fetch_allow;
  logic [DIM_W-1:0] remain;
  logic [CNT_W-1:0] cnt;
  logic [23:0]      head0, head1;
  logic             push, rd_avail, pair_ok, empty_flag;
  logic [1:0]       take_n, pop_n;

  assign active    = cfg_enable && cfg_reg_route;
  assign stream_on = cfg_enable && !cfg_reg_route;
  assign cmd_frame = host_wr && host_wcmd[1];
  assign cmd_line  = host_wr && host_wcmd[0];

  // Read availability: one pixel unpacked; two, or the last one of a line, packed.
  assign pair_ok  = cnt >= CNT_W'(2) && remain >= DIM_W'(2);
  assign take_n   = (cfg_pack && pair_ok) ? 2'd2 : 2'd1;
  assign rd_avail = active && state == ST_LINE &&
                    (cfg_pack ? (pair_ok || (cnt == CNT_W'(1) && remain == DIM_W'(1)))
                              : (cnt != '0));
  assign pop_n    = (host_rd && rd_avail) ? take_n : 2'd0;

  assign up_ready   = stream_on ? st_ready
                                : (active && fetch_allow && cnt < CNT_W'(DEPTH));
  assign push       = active && up_valid && up_ready;
  assign st_valid   = stream_on && up_valid;
  assign st_data    = stream_on ? up_data : 24'd0;
  assign empty_flag = cnt == '0 && !up_valid;

  always_comb begin
    if (!active)       host_rdata = 32'd0;
    else if (cfg_pack) host_rdata = packed_word(rd_avail ? take_n : 2'd0, head0, head1);
    else               host_rdata = status_word(eol, empty_flag, rd_avail, head0);
  end

  dfr_seq #(.DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .oneshot(cfg_oneshot),
    .width(cfg_width), .height(cfg_height), .cmd_frame(cmd_frame), .cmd_line(cmd_line),
    .pop_n(pop_n), .fetch(push), .state(state), .eol(eol),
    .fetch_allow(fetch_allow), .remain(remain)
  );

  dfr_prefetch #(.DEPTH(DEPTH), .PIX_W(24)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(!active), .push(push), .push_data(up_data),
    .pop_n(pop_n), .count(cnt), .head0(head0), .head1(head1)
  );

  // R2: streaming output only appears outside register-route mode.
  p_stream_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !active);

  // R12: the empty flag never claims empty while a read is possible.
  p_empty_vs_avail_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cfg_pack && rd_avail) |-> !host_rdata[25]);

endmodule

// File: tb/tb_dfr_readout_port.sv
module tb_dfr_readout_port;

  localparam int DW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_enable, cfg_reg_route, cfg_pack, cfg_oneshot;
  logic [DW-1:0] cfg_width, cfg_height;
  logic up_valid, up_ready, st_valid, st_ready, host_rd, host_wr;
  logic [23:0] up_data, st_data;
  logic [31:0] host_rdata;
  logic [1:0] host_wcmd;

  dfr_readout_port #(.DIM_W(DW), .DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_reg_route(cfg_reg_route),
    .cfg_pack(cfg_pack), .cfg_oneshot(cfg_oneshot), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_wr(host_wr), .host_wcmd(host_wcmd)
  );

  int nchk = 0, nerr = 0, gap = 0;
  logic fire = 1'b0;
  logic [23:0] up_q[$];
  logic [23:0] exp_q[$];

  function automatic logic [15:0] b565(input logic [23:0] p);
    return {p[23:19], p[15:10], p[7:3]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic send_cmd(input logic [1:0] c);
    tick(); host_wr = 1'b1; host_wcmd = c;
    @(posedge clk); #1; host_wr = 1'b0; host_wcmd = 2'b00;
  endtask

  task automatic push_pix(input int n);
    for (int i = 0; i < n; i++) begin
      logic [23:0] p;
      p = 24'($urandom) | 24'h080000;
      up_q.push_back(p); exp_q.push_back(p);
    end
  endtask

  // Upstream FIFO model: handshake decided mid-cycle, retired at the next falling edge.
  initial begin
    up_valid = 1'b0; up_data = 24'd0;
    forever begin
      @(negedge clk);
      if (fire && up_q.size() > 0) void'(up_q.pop_front());
      up_valid = up_q.size() > 0 && !(gap > 0 && int'($urandom % 100) < gap);
      up_data  = up_valid ? up_q[0] : 24'd0;
      #3; fire = up_valid && up_ready;
    end
  end

  task automatic read_unpk(input string tag);
    bit got;
    logic [23:0] e;
    logic [31:0] w;
    got = 1'b0;
    for (int k = 0; k < 80 && !got; k++) begin
      tick();
      if (host_rdata[24]) got = 1'b1;
    end
    w = host_rdata; host_rd = 1'b1; @(posedge clk); #1; host_rd = 1'b0;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 24'd0;
    // R3: flags around the pixel; empty bit masked since it depends on upstream timing
    check(tag, w & 32'hFDFF_FFFF, {5'd0, 1'b0, 1'b0, 1'b1, e});
  endtask

  task automatic read_pk(input string tag, input bit two);
    logic [31:0] w;
    logic [23:0] p0, p1;
    w = 32'd0;
    for (int k = 0; k < 80 && w == 32'd0; k++) begin
      tick(); w = host_rdata;
    end
    host_rd = 1'b1; @(posedge clk); #1; host_rd = 1'b0;
    p0 = exp_q.pop_front();
    p1 = two ? exp_q.pop_front() : 24'd0;
    check(tag, w, two ? {b565(p1), b565(p0)} : {16'd0, b565(p0)});
  endtask

  task automatic read_line(input int wd, input bit pk, input string tag);
    if (!pk) begin
      for (int i = 0; i < wd; i++) read_unpk(tag);
      tick();
      // R6: end-of-line up, valid down
      check({tag, "_R6_eol"}, {29'd0, host_rdata[26], 1'b0, host_rdata[24]}, 32'h4);
    end else begin
      for (int i = 0; i < wd; i += 2) read_pk(tag, (wd - i) >= 2);
    end
  endtask

  task automatic run_frame(input int wd, input int ht, input bit pk, input string tag);
    tick(); cfg_width = DW'(wd); cfg_height = DW'(ht); cfg_pack = pk;
    push_pix(wd * ht);
    send_cmd(2'b10);
    for (int r = 0; r < ht; r++) begin
      if (r > 0) send_cmd(2'b01);
      read_line(wd, pk, tag);
    end
  endtask

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_reg_route = 1'b0; cfg_pack = 1'b0; cfg_oneshot = 1'b0;
    cfg_width = DW'(1); cfg_height = DW'(1); st_ready = 1'b0;
    host_rd = 1'b0; host_wr = 1'b0; host_wcmd = 2'b00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check("R1_rdata", host_rdata, 32'd0);
    check("R1_ready", {31'd0, up_ready}, 32'd0);
    check("R1_stvalid", {31'd0, st_valid}, 32'd0);

    // R2: streaming pass-through
    cfg_enable = 1'b1; st_ready = 1'b1;
    for (int i = 0; i < 3; i++) up_q.push_back(24'($urandom));
    tick();
    for (int k = 0; k < 20 && up_q.size() > 0; k++) begin
      check("R2_stvalid", {31'd0, st_valid}, {31'd0, up_valid});
      check("R2_stdata", {8'd0, st_data}, {8'd0, up_q[0]});
      check("R2_ready", {31'd0, up_ready}, 32'd1);
      check("R2_rdata", host_rdata, 32'd0);
      tick();
    end
    st_ready = 1'b0; up_q.push_back(24'h123456); tick();
    check("R2_ready_low", {31'd0, up_ready}, 32'd0);
    st_ready = 1'b1; tick(); tick();
    send_cmd(2'b10);               // frame start in streaming mode: no effect
    tick(); st_ready = 1'b0;
    up_q.delete();
    // R12: nothing buffered and upstream empty
    cfg_reg_route = 1'b1; tick(); tick();
    check("R12_empty", {31'd0, host_rdata[25]}, 32'd1);
    push_pix(2);
    repeat (5) tick();
    check("R2_cmd_ignored", host_rdata & 32'h05FF_FFFF, 32'd0);
    check("R12_not_empty", {31'd0, host_rdata[25]}, 32'd0);

    // R4/R5/R7: directed 3x2 frame
    cfg_width = DW'(3); cfg_height = DW'(2);
    push_pix(4);
    send_cmd(2'b10);
    tick();
    host_rd = 1'b1;
    check("R5_invalid_read", host_rdata & 32'h01FF_FFFF, 32'd0);
    @(posedge clk); #1; host_rd = 1'b0;
    read_unpk("R4_first");
    send_cmd(2'b01);               // line start mid-line: ignored
    read_unpk("R7_midline");
    read_unpk("R4_third");
    tick();
    check("R6_eol", {29'd0, host_rdata[26:24]}, 32'h4);   // upstream still holds pixels
    host_rd = 1'b1; @(posedge clk); #1; host_rd = 1'b0;   // read during end-of-line
    send_cmd(2'b01);
    tick();
    check("R6_eol_clear", {31'd0, host_rdata[26]}, 32'd0);
    read_line(3, 1'b0, "R5_no_pop");
    send_cmd(2'b01);               // after last line: ignored
    push_pix(2);
    repeat (5) tick();
    check("R7_frame_over", {31'd0, host_rdata[24]}, 32'd0);
    check("R7_eol_stays", {31'd0, host_rdata[26]}, 32'd1);
    cfg_width = DW'(2); cfg_height = DW'(1);
    send_cmd(2'b10);
    read_line(2, 1'b0, "R7_new_frame");

    // R8: one-shot
    cfg_oneshot = 1'b1;
    run_frame(2, 1, 1'b0, "R8_frame");
    push_pix(2);
    send_cmd(2'b10);
    repeat (6) tick();
    check("R8_ignored", {31'd0, host_rdata[24]}, 32'd0);
    cfg_enable = 1'b0; tick();
    check("R11_off_rdata", host_rdata, 32'd0);
    cfg_enable = 1'b1; cfg_oneshot = 1'b0;
    send_cmd(2'b10);
    read_line(2, 1'b0, "R11_reenable");

    // R11: disable mid-line drops buffered pixels
    tick(); cfg_width = DW'(4); cfg_height = DW'(1);
    push_pix(4);
    send_cmd(2'b10);
    read_unpk("R11_before");
    repeat (3) tick();
    cfg_enable = 1'b0; tick();
    check("R11_rdata", host_rdata, 32'd0);
    check("R11_ready", {31'd0, up_ready}, 32'd0);
    up_q.delete(); exp_q.delete();
    tick(); tick();
    cfg_enable = 1'b1;
    push_pix(2);
    repeat (5) tick();
    check("R11_wait_frame", {31'd0, host_rdata[24]}, 32'd0);
    check("R11_ready_wait", {31'd0, up_ready}, 32'd0);
    tick(); cfg_width = DW'(2);
    send_cmd(2'b10);
    read_line(2, 1'b0, "R11_fresh");

    // R9/R10: packed
    run_frame(4, 1, 1'b1, "R9_even");
    run_frame(3, 2, 1'b1, "R10_odd");
    run_frame(1, 1, 1'b1, "R10_single");

    // Random frames with upstream gaps in unpacked mode
    for (int f = 0; f < 10; f++) begin
      int wd, ht;
      bit pk;
      wd = 1 + int'($urandom % 7);
      ht = 1 + int'($urandom % 3);
      pk = 1'($urandom % 2);
      gap = pk ? 0 : 30;
      run_frame(wd, ht, pk, pk ? "R9_rand" : "R4_rand");
      gap = 0;
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule